// File: doc/BRIEF.md
# Status register and block-lock protection unit

This block keeps the eight-bit status word of a serial memory and decides, each cycle, whether an array write at a given address or a status write may go ahead. It holds three retained bits: a status-lock enable and a two-bit range-lock code. It also holds three volatile bits: a software flag, the write-enable latch and a busy indicator that is set while an internal write cycle runs. A command decoder elsewhere feeds it one-cycle strobes. It returns the status byte for a status read and two permission levels that the decoder consults.

Status writes can be locked by the write-protect pin together with the lock-enable bit, and array writes are locked by address range. A request that passes the check starts a write cycle and sets the busy bit. A separate timer pulses completion. On completion a staged status value is committed and the write-enable latch is cleared. The check is made only when the request arrives, so the cycle that is already running still commits if the pin drops to low partway through it.

Top module: `wprot_status_unit`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0, lock-enable, flag, 1, 1, range code high bit, range code low bit, write-enable latch, busy. Bits 5 and 4 always read 1. After the first logic reset with default parameters it reads 0x30.
- R2: An enable strobe sets the write-enable latch. A set-flag strobe sets the flag. The disable strobe clears both the latch and the flag.
- R3: While the write-enable latch is 0, both permission outputs are 0, and no array or status request starts a cycle.
- R4: With a 12-bit address, range code 00 locks nothing, 01 locks 0xC00–0xFFF, 10 locks 0x800–0xFFF and 11 locks all addresses. An array request to a locked address starts no cycle, and array permission is 0 for it.
- R5: When lock-enable is 1 and the protect pin is low, status permission is 0 and a status request starts no cycle. When lock-enable is 0, the pin has no effect.
- R6: An accepted status write changes only lock-enable (data bit 7) and the range code (data bits 3..2). The change becomes visible at cycle completion, and the other data bits are discarded.
- R7: An accepted request sets busy, and completion clears it. While busy, both permissions are 0 and further requests are refused. A completion pulse ends an array cycle without altering the retained bits.
- R8: Every completed cycle clears the write-enable latch. This holds even when an enable strobe arrives in the same cycle as the completion.
- R9: A status cycle that began while writes were permitted still commits if the pin goes low mid-cycle. Once lock-enable is 1 and the pin is low, later status requests are refused.
- R10: The synchronous reset clears the latch, the flag and busy, and drops a pending status write, so a later completion pulse commits nothing. It leaves the retained bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high logic reset |
| wp_pin | input | 1 | Write-protect pin level, low means protect |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Disable strobe, clears latch and flag |
| cmd_sflag | input | 1 | Set-flag strobe |
| cmd_wrsr | input | 1 | Status write request strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| arr_req | input | 1 | Array write request strobe |
| cyc_done | input | 1 | Write-cycle completion pulse from the timer |
| tgt_addr | input | ADDR_W | Address the array permission is judged for |
| status_o | output | 8 | Status byte |
| arr_wr_ok | output | 1 | Array write at tgt_addr permitted |
| stat_wr_ok | output | 1 | Status write permitted |

## Verification
Two functions can fall in the same cycle. The first pair is a completion pulse and an enable strobe. The bench drives both in one cycle and expects the latch to read 0 afterwards. The second pair is a running status cycle and a protect-pin drop. The bench starts a status write that sets lock-enable, drops the pin before completion, and then requires both the committed value and a refusal of the next status request.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int STAT_W = 8;
  // status bits that a status write may change: lock-enable and range code
  localparam logic [STAT_W-1:0] NV_MASK  = 8'h8C;
  localparam logic [STAT_W-1:0] ONES_FIX = 8'h30;
  localparam int LOCK_POS = 7;
  localparam int FLAG_POS = 6;
  localparam int RNG_HI   = 3;
  localparam int RNG_LO   = 2;
  localparam int WEL_POS  = 1;
  localparam int BUSY_POS = 0;
endpackage

// File: rtl/wprot_range_chk.sv
module wprot_range_chk #(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        rng_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam logic [ADDR_W-1:0] QTR_TOP  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_TOP = {2'b10, {(ADDR_W-2){1'b0}}};

  generate
    if (ADDR_W < 2) begin : g_bad
      initial $display("wprot_range_chk: ADDR_W must be at least 2");
    end
  endgenerate

  always_comb begin
    unique case (rng_i)
      2'b00:   locked_o = 1'b0;
      2'b01:   locked_o = (addr_i >= QTR_TOP);
      2'b10:   locked_o = (addr_i >= HALF_TOP);
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_nv_reg.sv
module wprot_nv_reg
  import wprot_pkg::*;
#(
  parameter logic [STAT_W-1:0] NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [STAT_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              busy_i,
  output logic [STAT_W-1:0] nv_o
);
  // retained word: not touched by the logic reset
  logic [STAT_W-1:0] nv_q = NV_INIT & NV_MASK;
  logic [STAT_W-1:0] pend_q = '0;

  always_ff @(posedge clk) begin
    if (capture_i) pend_q <= data_i & NV_MASK;
    if (commit_i)  nv_q   <= pend_q;
  end

  assign nv_o = nv_q;

  // R6
  nv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(nv_q));
  // R7
  commit_busy_chk: assert property (@(posedge clk) disable iff (rst)
    commit_i |-> busy_i);
endmodule

// File: rtl/wprot_vol_reg.sv
module wprot_vol_reg (
  input  logic clk,
  input  logic rst,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic sflag_i,
  input  logic arr_go_i,
  input  logic stat_go_i,
  input  logic done_i,
  output logic wel_o,
  output logic flag_o,
  output logic busy_o,
  output logic commit_o
);
  logic wel_q, flag_q, busy_q, stat_cyc_q;
  logic finish;

  assign finish = done_i & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q      <= 1'b0;
      flag_q     <= 1'b0;
      busy_q     <= 1'b0;
      stat_cyc_q <= 1'b0;
    end else begin
      if (finish)                    busy_q <= 1'b0;
      else if (arr_go_i | stat_go_i) busy_q <= 1'b1;

      if (finish)         stat_cyc_q <= 1'b0;
      else if (stat_go_i) stat_cyc_q <= 1'b1;
      else if (arr_go_i)  stat_cyc_q <= 1'b0;

      if (finish)      wel_q <= 1'b0;
      else if (wrdi_i) wel_q <= 1'b0;
      else if (wren_i) wel_q <= 1'b1;

      if (wrdi_i)       flag_q <= 1'b0;
      else if (sflag_i) flag_q <= 1'b1;
    end
  end

  assign wel_o    = wel_q;
  assign flag_o   = flag_q;
  assign busy_o   = busy_q;
  assign commit_o = finish & stat_cyc_q;

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(arr_go_i || stat_go_i));
  // R8
  wel_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wel_q) |-> $past(rst || wrdi_i || (done_i && busy_q)));
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
  import wprot_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter logic [STAT_W-1:0] NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_pin,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_sflag,
  input  logic              cmd_wrsr,
  input  logic [STAT_W-1:0] wrsr_data,
  input  logic              arr_req,
  input  logic              cyc_done,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [STAT_W-1:0] status_o,
  output logic              arr_wr_ok,
  output logic              stat_wr_ok
);
  logic [STAT_W-1:0] nv_word;
  logic wel, flag, busy, commit;
  logic addr_locked, rom_lock, base_ok, stat_go, arr_go;

  wprot_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .rng_i    (nv_word[RNG_HI:RNG_LO]),
    .addr_i   (tgt_addr),
    .locked_o (addr_locked)
  );

  assign base_ok  = wel & ~busy;
  assign rom_lock = nv_word[LOCK_POS] & ~wp_pin;
  assign stat_go  = cmd_wrsr & base_ok & ~rom_lock;
  assign arr_go   = arr_req & ~cmd_wrsr & base_ok & ~addr_locked;

  wprot_nv_reg #(.NV_INIT(NV_INIT)) u_nv (
    .clk       (clk),
    .rst       (rst),
    .capture_i (stat_go),
    .data_i    (wrsr_data),
    .commit_i  (commit),
    .busy_i    (busy),
    .nv_o      (nv_word)
  );

  wprot_vol_reg u_vol (
    .clk       (clk),
    .rst       (rst),
    .wren_i    (cmd_wren),
    .wrdi_i    (cmd_wrdi),
    .sflag_i   (cmd_sflag),
    .arr_go_i  (arr_go),
    .stat_go_i (stat_go),
    .done_i    (cyc_done),
    .wel_o     (wel),
    .flag_o    (flag),
    .busy_o    (busy),
    .commit_o  (commit)
  );

  always_comb begin
    status_o           = (nv_word & NV_MASK) | ONES_FIX;
    status_o[FLAG_POS] = flag;
    status_o[WEL_POS]  = wel;
    status_o[BUSY_POS] = busy;
  end

  assign arr_wr_ok  = base_ok & ~addr_locked;
  assign stat_wr_ok = base_ok & ~rom_lock;

  // R3
  wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !wel |=> !$rose(busy));
  // R4
  range_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_req && !cmd_wrsr && addr_locked) |=> !$rose(busy));
  // R5
  rom_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wrsr && !arr_req && nv_word[LOCK_POS] && !wp_pin) |=> !$rose(busy));
endmodule

// File: tb/wprot_status_unit_tb.sv
module wprot_status_unit_tb;
  localparam int AW = 12;
  localparam logic [2:0] OP_NOP = 3'd0, OP_WREN = 3'd1, OP_WRDI = 3'd2,
                         OP_SFLG = 3'd3, OP_WRSR = 3'd4, OP_AREQ = 3'd5,
                         OP_DONE = 3'd6, OP_WDN = 3'd7;
  localparam int NV = 20;
  // fields: req[3:0] op[2:0] data[7:0] wp addr[11:0] status[7:0] arr_ok stat_ok
  localparam logic [37:0] VEC [NV] = '{
    {4'd1, OP_NOP,  8'h00, 1'b1, 12'h000, 8'h30, 1'b0, 1'b0}, // R1 R3
    {4'd2, OP_WREN, 8'h00, 1'b1, 12'h000, 8'h32, 1'b1, 1'b1}, // R2
    {4'd2, OP_SFLG, 8'h00, 1'b1, 12'h000, 8'h72, 1'b1, 1'b1}, // R2
    {4'd2, OP_WRDI, 8'h00, 1'b1, 12'h000, 8'h30, 1'b0, 1'b0}, // R2
    {4'd3, OP_AREQ, 8'h00, 1'b1, 12'h100, 8'h30, 1'b0, 1'b0}, // R3
    {4'd2, OP_WREN, 8'h00, 1'b1, 12'h100, 8'h32, 1'b1, 1'b1}, // R2
    {4'd7, OP_WRSR, 8'h04, 1'b1, 12'h100, 8'h33, 1'b0, 1'b0}, // R7
    {4'd6, OP_DONE, 8'h00, 1'b1, 12'h100, 8'h34, 1'b0, 1'b0}, // R6
    {4'd4, OP_WREN, 8'h00, 1'b1, 12'hC00, 8'h36, 1'b0, 1'b1}, // R4
    {4'd4, OP_NOP,  8'h00, 1'b1, 12'hBFF, 8'h36, 1'b1, 1'b1}, // R4
    {4'd4, OP_AREQ, 8'h00, 1'b1, 12'hC00, 8'h36, 1'b0, 1'b1}, // R4
    {4'd7, OP_AREQ, 8'h00, 1'b1, 12'hBFF, 8'h37, 1'b0, 1'b0}, // R7
    {4'd8, OP_DONE, 8'h00, 1'b1, 12'hBFF, 8'h34, 1'b0, 1'b0}, // R8
    {4'd2, OP_WREN, 8'h00, 1'b1, 12'hBFF, 8'h36, 1'b1, 1'b1}, // R2
    {4'd7, OP_WRSR, 8'hFB, 1'b1, 12'hBFF, 8'h37, 1'b0, 1'b0}, // R7
    {4'd6, OP_DONE, 8'h00, 1'b1, 12'hBFF, 8'hB8, 1'b0, 1'b0}, // R6
    {4'd4, OP_WREN, 8'h00, 1'b1, 12'h7FF, 8'hBA, 1'b1, 1'b1}, // R4
    {4'd5, OP_NOP,  8'h00, 1'b0, 12'h800, 8'hBA, 1'b0, 1'b0}, // R5
    {4'd5, OP_WRSR, 8'h00, 1'b0, 12'h800, 8'hBA, 1'b0, 1'b0}, // R5
    {4'd5, OP_NOP,  8'h00, 1'b1, 12'h800, 8'hBA, 1'b0, 1'b1}  // R5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_pin = 1'b1;
  logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_sflag = 1'b0, cmd_wrsr = 1'b0;
  logic arr_req = 1'b0, cyc_done = 1'b0;
  logic [7:0] wrsr_data = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic [7:0] status_o;
  logic arr_wr_ok, stat_wr_ok;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wprot_status_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wp_pin(wp_pin), .cmd_wren(cmd_wren),
    .cmd_wrdi(cmd_wrdi), .cmd_sflag(cmd_sflag), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .arr_req(arr_req), .cyc_done(cyc_done),
    .tgt_addr(tgt_addr), .status_o(status_o), .arr_wr_ok(arr_wr_ok),
    .stat_wr_ok(stat_wr_ok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] d, input logic w,
                      input logic [AW-1:0] a);
    wp_pin = w; tgt_addr = a; wrsr_data = d;
    cmd_wren  = (op == OP_WREN) || (op == OP_WDN);
    cmd_wrdi  = (op == OP_WRDI);
    cmd_sflag = (op == OP_SFLG);
    cmd_wrsr  = (op == OP_WRSR);
    arr_req   = (op == OP_AREQ);
    cyc_done  = (op == OP_DONE) || (op == OP_WDN);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_sflag, cmd_wrsr, arr_req, cyc_done} = '0;
  endtask

  task automatic pulse_rst();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", status_o, 8'h30);
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      string tag;
      v = VEC[i];
      step(v[33:31], v[30:23], v[22], v[21:10]);
      tag = $sformatf("R%0d vec%0d", v[37:34], i);
      chk(tag, status_o, v[9:2]);
      chk(tag, {7'd0, arr_wr_ok}, {7'd0, v[1]});
      chk(tag, {7'd0, stat_wr_ok}, {7'd0, v[0]});
    end
    // R9 pin drops low during a status cycle that sets lock-enable
    step(OP_WRSR, 8'h8C, 1'b1, 12'h800); chk("R9", status_o, 8'hBB);
    step(OP_NOP,  8'h00, 1'b0, 12'h800); chk("R9", status_o, 8'hBB);
    step(OP_DONE, 8'h00, 1'b0, 12'h800); chk("R9", status_o, 8'hBC);
    step(OP_WREN, 8'h00, 1'b0, 12'h000); chk("R9", status_o, 8'hBE);
    chk("R9", {7'd0, stat_wr_ok}, 8'h00);
    chk("R4", {7'd0, arr_wr_ok}, 8'h00);
    step(OP_WRSR, 8'h00, 1'b0, 12'h000); chk("R9", status_o, 8'hBE);
    // R10 reset keeps retained bits, clears volatile ones
    step(OP_SFLG, 8'h00, 1'b0, 12'h000); chk("R2", status_o, 8'hFE);
    pulse_rst();                          chk("R10", status_o, 8'hBC);
    step(OP_WREN, 8'h00, 1'b1, 12'h000);
    step(OP_WRSR, 8'h00, 1'b1, 12'h000); chk("R10", status_o, 8'hBF);
    pulse_rst();                          chk("R10", status_o, 8'hBC);
    step(OP_DONE, 8'h00, 1'b1, 12'h000); chk("R10", status_o, 8'hBC);
    // R8 enable strobe coinciding with completion
    step(OP_WREN, 8'h00, 1'b1, 12'h000);
    step(OP_WRSR, 8'h00, 1'b1, 12'h000); chk("R8", status_o, 8'hBF);
    step(OP_WDN,  8'h00, 1'b1, 12'h000); chk("R8", status_o, 8'h30);
    // R5 pin ignored with lock-enable clear
    step(OP_WREN, 8'h00, 1'b0, 12'hFFF); chk("R5", status_o, 8'h32);
    chk("R5", {7'd0, stat_wr_ok}, 8'h01);
    chk("R4", {7'd0, arr_wr_ok}, 8'h01);
    // R7 busy refuses requests, array completion commits nothing
    step(OP_AREQ, 8'h00, 1'b0, 12'hFFF); chk("R7", status_o, 8'h33);
    step(OP_WRSR, 8'h8C, 1'b0, 12'hFFF); chk("R7", status_o, 8'h33);
    chk("R7", {6'd0, arr_wr_ok, stat_wr_ok}, 8'h00);
    step(OP_DONE, 8'h00, 1'b0, 12'hFFF); chk("R7", status_o, 8'h30);
    finished = 1'b1;
    report();
  end
endmodule